// File: doc/BRIEF.md
# Bit-Plane Coefficient Reconstruction Unit

This unit rebuilds one frame of quantized spectral magnitudes from a stream of bit-planes. Each plane carries one bit for every coefficient of the frame, with the coefficients laid out in frequency-band order, and every bit in a plane sits at the same significance. Planes come in from the most significant position downward. The first plane is the base layer, and on its own it yields a coarse but usable frame. Each later plane is an enhancement layer that adds one more bit of precision to every coefficient.

A frame-start pulse clears the register file and the layer count. Planes are then taken in over a valid/ready handshake, and each carries the index of the layer it belongs to. A truncate command can end the frame after any number of layers. The stored values are then read out in ascending coefficient order, and bits that were never received read as zero. One sign bit per coefficient comes in alongside the base layer. A plane whose layer index does not match the next expected layer is dropped and sets a sticky error flag. The unit can also emit a one-cycle pulse after every Nth enhancement layer, which tells the upstream entropy decoder to restart its state.

Top module: `bitplane_recon`

## Requirements
- R1: After reset, rd_valid, plane_ready, order_err and seg_reset are 0 and layers_rcvd is 0.
- R2: On the cycle after frame_start, every coefficient magnitude and sign is 0, layers_rcvd is 0, order_err is 0 and plane_ready is 1.
- R3: An accepted plane whose plane_layer equals layers_rcvd (k) copies plane_bits[i] into bit MAG_W-1-k of coefficient i, for every i. layers_rcvd then rises by one.
- R4: A coefficient's sign is taken from plane_sign[i] of the layer-0 plane only. The plane_sign value of any later plane has no effect.
- R5: A plane whose plane_layer differs from layers_rcvd is consumed but discarded. Coefficients and layers_rcvd stay unchanged, and order_err goes to 1 and stays there until the next frame_start.
- R6: truncate while accepting planes ends acceptance and starts read-out. A valid plane presented in the same cycle as truncate is still applied.
- R7: Read-out presents coefficient index 0 up to NUM_COEF-1, one per rd_valid/rd_ready handshake, and raises rd_last on the final index. Each magnitude holds the received high bits with every lower bit zero.
- R8: While rd_valid is 1 and rd_ready is 0, rd_index and the presented coefficient do not change.
- R9: After the final read-out handshake, rd_valid and plane_ready are 0. Planes are refused until the next frame_start.
- R10: When seg_en is 1, seg_reset pulses for one cycle right after acceptance of enhancement layer k (k >= 1) whenever k is a multiple of SEG_LEN. It never pulses for the base layer or when seg_en is 0.
- R11: Once MAG_W planes have been accepted, any further plane counts as out of order (R5), including an index of MAG_W or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Clears the frame and begins plane acceptance |
| seg_en | input | 1 | Enables the periodic entropy-restart pulse |
| plane_valid | input | 1 | Plane present |
| plane_ready | output | 1 | Unit is accepting planes |
| plane_layer | input | LAYER_W | Layer index of the plane (0 = base) |
| plane_bits | input | NUM_COEF | One magnitude bit per coefficient, band ordered |
| plane_sign | input | NUM_COEF | Sign bits, used with the base layer |
| truncate | input | 1 | End of frame; start read-out |
| rd_valid | output | 1 | Read-out coefficient present |
| rd_ready | input | 1 | Consumer takes the coefficient |
| rd_index | output | IDX_W | Index of presented coefficient |
| rd_mag | output | MAG_W | Reconstructed magnitude |
| rd_sign | output | 1 | Sign of presented coefficient |
| rd_last | output | 1 | Final coefficient of the frame |
| layers_rcvd | output | LAYER_W+1 | Number of layers applied this frame |
| order_err | output | 1 | Sticky out-of-order plane flag |
| seg_reset | output | 1 | One-cycle entropy-state restart pulse |

## Verification
The bench builds the unit with eight coefficients, six-bit magnitudes and a segment length of two. With these values it can stop a frame after every possible prefix, from zero layers up to all six, and check each truncated value bit by bit in a handful of cycles. The short segment length means every frame longer than two layers triggers restart pulses, with seg_en both on and off. The small depth also brings the end-of-planes boundary and the out-of-range layer indices within reach.

// File: rtl/bpr_pkg.sv
// Shared types for the bit-plane reconstruction unit.
package bpr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DRAIN = 2'd2
    } bpr_state_e;
endpackage

// File: rtl/bpr_plane_ctrl.sv
// Plane sequencer: tracks the frame state and the expected layer, flags
// out-of-order planes and generates the segment restart pulse.
// Assumes frame_start takes priority over every other input.
module bpr_plane_ctrl
    import bpr_pkg::*;
#(
    parameter int MAG_W   = 16,
    parameter int SEG_LEN = 4,
    localparam int LAYER_W = $clog2(MAG_W),
    localparam int CNT_W   = LAYER_W + 1,
    localparam int SEG_W   = $clog2(SEG_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               truncate,
    input  logic               seg_en,
    input  logic               plane_valid,
    input  logic [LAYER_W-1:0] plane_layer,
    input  logic               drain_done,
    output logic               plane_ready,
    output logic               accept,
    output logic               start_drain,
    output logic               draining,
    output logic [CNT_W-1:0]   layers_rcvd,
    output logic               order_err,
    output logic               seg_reset
);
    bpr_state_e       state;
    logic [CNT_W-1:0] layer_cnt;
    logic [SEG_W-1:0] seg_cnt;
    logic             handshake;
    logic             in_order;

    // Decode handshake, ordering and the drain entry.
    always_comb begin
        plane_ready = (state == ST_ACCUM);
        handshake   = plane_valid && plane_ready;
        in_order    = (layer_cnt < CNT_W'(MAG_W)) &&
                      (CNT_W'(plane_layer) == layer_cnt);
        accept      = handshake && in_order;
        start_drain = (state == ST_ACCUM) && truncate;
        draining    = (state == ST_DRAIN);
        layers_rcvd = layer_cnt;
    end

    // Frame state, layer count, error flag and segment counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            layer_cnt <= '0;
            seg_cnt   <= '0;
            order_err <= 1'b0;
            seg_reset <= 1'b0;
        end else if (frame_start) begin
            state     <= ST_ACCUM;
            layer_cnt <= '0;
            seg_cnt   <= '0;
            order_err <= 1'b0;
            seg_reset <= 1'b0;
        end else begin
            seg_reset <= 1'b0;
            if (accept) begin
                layer_cnt <= layer_cnt + CNT_W'(1);
                if (layer_cnt != '0) begin
                    if (seg_cnt == SEG_W'(SEG_LEN - 1)) begin
                        seg_cnt   <= '0;
                        seg_reset <= seg_en;
                    end else begin
                        seg_cnt <= seg_cnt + SEG_W'(1);
                    end
                end
            end
            if (handshake && !in_order) begin
                order_err <= 1'b1;
            end
            if (start_drain) begin
                state <= ST_DRAIN;
            end else if (draining && drain_done) begin
                state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/bpr_coef_bank.sv
// Coefficient register file: each accepted plane ORs its bits into one
// significance position of every coefficient; signs come from layer 0.
// Assumes clear arrives before the first plane of a frame.
module bpr_coef_bank #(
    parameter int NUM_COEF = 64,
    parameter int MAG_W    = 16,
    localparam int IDX_W   = $clog2(NUM_COEF),
    localparam int LAYER_W = $clog2(MAG_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                wr_en,
    input  logic [LAYER_W-1:0]  wr_layer,
    input  logic [NUM_COEF-1:0] wr_bits,
    input  logic [NUM_COEF-1:0] wr_sign,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [MAG_W-1:0]    rd_mag,
    output logic                rd_sign
);
    logic [MAG_W-1:0] mag_q  [NUM_COEF];
    logic             sign_q [NUM_COEF];
    logic [MAG_W-1:0] pos_mask;

    // One-hot mask of the bit position this layer fills.
    always_comb begin
        pos_mask = '0;
        for (int b = 0; b < MAG_W; b++) begin
            if (b == MAG_W - 1 - int'(wr_layer)) pos_mask[b] = 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_COEF; g++) begin : g_coef
        // Per-coefficient accumulation of magnitude bits and sign.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                mag_q[g]  <= '0;
                sign_q[g] <= 1'b0;
            end else if (wr_en) begin
                mag_q[g] <= mag_q[g] | (wr_bits[g] ? pos_mask : '0);
                if (wr_layer == '0) sign_q[g] <= wr_sign[g];
            end
        end
    end

    // Read-out selection.
    always_comb begin
        rd_mag  = mag_q[rd_idx];
        rd_sign = sign_q[rd_idx];
    end
endmodule

// File: rtl/bpr_readout.sv
// Sequential read-out pointer with a valid/ready handshake.
// Assumes active is held until done and that start precedes active.
module bpr_readout #(
    parameter int NUM_COEF = 64,
    localparam int IDX_W   = $clog2(NUM_COEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rd_last,
    output logic             done
);
    // Handshake outputs.
    always_comb begin
        rd_valid = active;
        rd_last  = active && (rd_idx == IDX_W'(NUM_COEF - 1));
        done     = rd_last && rd_ready;
    end

    // Pointer advance on each taken coefficient.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            rd_idx <= '0;
        end else if (active && rd_ready) begin
            rd_idx <= rd_last ? '0 : rd_idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/bitplane_recon.sv
// Top of the bit-plane reconstruction unit: wires sequencer, register file
// and read-out pointer. Assumes NUM_COEF is a power of two and SEG_LEN >= 1.
module bitplane_recon #(
    parameter int NUM_COEF = 64,
    parameter int MAG_W    = 16,
    parameter int SEG_LEN  = 4,
    localparam int IDX_W   = $clog2(NUM_COEF),
    localparam int LAYER_W = $clog2(MAG_W),
    localparam int CNT_W   = LAYER_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                seg_en,
    input  logic                plane_valid,
    output logic                plane_ready,
    input  logic [LAYER_W-1:0]  plane_layer,
    input  logic [NUM_COEF-1:0] plane_bits,
    input  logic [NUM_COEF-1:0] plane_sign,
    input  logic                truncate,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [IDX_W-1:0]    rd_index,
    output logic [MAG_W-1:0]    rd_mag,
    output logic                rd_sign,
    output logic                rd_last,
    output logic [CNT_W-1:0]    layers_rcvd,
    output logic                order_err,
    output logic                seg_reset
);
    logic accept;
    logic start_drain;
    logic draining;
    logic drain_done;

    bpr_plane_ctrl #(.MAG_W(MAG_W), .SEG_LEN(SEG_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .truncate(truncate), .seg_en(seg_en), .plane_valid(plane_valid),
        .plane_layer(plane_layer), .drain_done(drain_done),
        .plane_ready(plane_ready), .accept(accept),
        .start_drain(start_drain), .draining(draining),
        .layers_rcvd(layers_rcvd), .order_err(order_err),
        .seg_reset(seg_reset)
    );

    bpr_coef_bank #(.NUM_COEF(NUM_COEF), .MAG_W(MAG_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear(frame_start), .wr_en(accept),
        .wr_layer(plane_layer), .wr_bits(plane_bits), .wr_sign(plane_sign),
        .rd_idx(rd_index), .rd_mag(rd_mag), .rd_sign(rd_sign)
    );

    bpr_readout #(.NUM_COEF(NUM_COEF)) u_rd (
        .clk(clk), .rst_n(rst_n), .restart(frame_start || start_drain),
        .active(draining), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_idx(rd_index), .rd_last(rd_last), .done(drain_done)
    );
endmodule

// File: rtl/bpr_checker.sv
// Port-level protocol checks for the bit-plane reconstruction unit.
module bpr_checker #(
    parameter int NUM_COEF = 64,
    parameter int MAG_W    = 16,
    localparam int IDX_W   = $clog2(NUM_COEF),
    localparam int CNT_W   = $clog2(MAG_W) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             seg_en,
    input logic             plane_valid,
    input logic             plane_ready,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [IDX_W-1:0] rd_index,
    input logic             rd_last,
    input logic [CNT_W-1:0] layers_rcvd,
    input logic             order_err,
    input logic             seg_reset
);
    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> (layers_rcvd == '0 && !order_err && plane_ready));

    p_layer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (layers_rcvd != $past(layers_rcvd)) |->
        ($past(frame_start) || layers_rcvd == $past(layers_rcvd) + CNT_W'(1)));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(order_err) && !$past(frame_start)) |-> order_err);

    p_no_plane_in_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !plane_ready);

    p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_valid && !rd_ready) && !$past(frame_start)) |->
        (rd_valid && $stable(rd_index)));

    p_seg_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_reset |-> ($past(seg_en) && $past(plane_valid && plane_ready)));

    p_layer_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        layers_rcvd <= CNT_W'(MAG_W));
endmodule

bind bitplane_recon bpr_checker #(.NUM_COEF(NUM_COEF), .MAG_W(MAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .seg_en(seg_en),
    .plane_valid(plane_valid), .plane_ready(plane_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_index(rd_index),
    .rd_last(rd_last), .layers_rcvd(layers_rcvd), .order_err(order_err),
    .seg_reset(seg_reset)
);

// File: tb/bitplane_recon_tb.sv
// Sweep bench: every truncation depth, ordering faults and read-out stalls.
module bitplane_recon_tb;
    localparam int NC = 8;
    localparam int MW = 6;
    localparam int SL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          seg_en = 1'b0;
    logic          plane_valid = 1'b0;
    logic          plane_ready;
    logic [2:0]    plane_layer = '0;
    logic [NC-1:0] plane_bits = '0;
    logic [NC-1:0] plane_sign = '0;
    logic          truncate = 1'b0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [2:0]    rd_index;
    logic [MW-1:0] rd_mag;
    logic          rd_sign;
    logic          rd_last;
    logic [3:0]    layers_rcvd;
    logic          order_err;
    logic          seg_reset;

    int n_chk = 0;
    int n_bad = 0;
    int seg_pulses = 0;
    bit finished = 0;
    int val [NC];
    bit sgn [NC];

    always #10 clk = ~clk;

    bitplane_recon #(.NUM_COEF(NC), .MAG_W(MW), .SEG_LEN(SL)) u_dut (.*);

    always @(negedge clk) if (seg_reset === 1'b1) seg_pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int masked(input int v, input int t);
        if (t == 0) return 0;
        return (v >> (MW - t)) << (MW - t);
    endfunction

    function automatic logic [NC-1:0] plane_of(input int k);
        logic [NC-1:0] p;
        for (int i = 0; i < NC; i++) p[i] = val[i][MW-1-k];
        return p;
    endfunction

    function automatic logic [NC-1:0] signs_of();
        logic [NC-1:0] s;
        for (int i = 0; i < NC; i++) s[i] = sgn[i];
        return s;
    endfunction

    task automatic new_frame(input int f);
        for (int i = 0; i < NC; i++) begin
            val[i] = (i * 23 + f * 13 + 7) % 64;
            sgn[i] = ((i + f) % 2) == 1;
        end
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        seg_pulses = 0;
        chk(layers_rcvd == 0 && plane_ready && !order_err, "R2", layers_rcvd, 0);
    endtask

    task automatic send(input int layer, input logic [NC-1:0] bits,
                        input logic [NC-1:0] signs, input bit trunc);
        @(negedge clk);
        plane_valid = 1'b1;
        plane_layer = 3'(layer);
        plane_bits  = bits;
        plane_sign  = signs;
        truncate    = trunc;
        @(negedge clk);
        plane_valid = 1'b0;
        truncate    = 1'b0;
    endtask

    task automatic drain(input int t, input int stall, input bit trunc_now);
        if (trunc_now) begin
            @(negedge clk);
            truncate = 1'b1;
            @(negedge clk);
            truncate = 1'b0;
        end
        rd_ready = 1'b0;
        for (int s = 0; s < stall; s++) begin
            chk(rd_valid && rd_index == 0, "R8", rd_index, 0);
            @(negedge clk);
        end
        rd_ready = 1'b1;
        for (int k = 0; k < NC; k++) begin
            chk(rd_valid && rd_index == 3'(k), "R7 index", rd_index, k);
            chk(rd_mag == MW'(masked(val[k], t)), "R7 magnitude", rd_mag, masked(val[k], t));
            chk(rd_sign == (t > 0 ? sgn[k] : 1'b0), "R4 sign", rd_sign, t > 0 ? sgn[k] : 0);
            chk(rd_last == (k == NC - 1), "R7 last", rd_last, k == NC - 1);
            @(negedge clk);
        end
        rd_ready = 1'b0;
        chk(!rd_valid && !plane_ready, "R9", rd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_valid && !plane_ready && !order_err && !seg_reset && layers_rcvd == 0,
            "R1", rd_valid, 0);
        rst_n = 1'b1;

        // R3 R4 R7 R10: every truncation depth, seg_en both ways.
        for (int t = 0; t <= MW; t++) begin
            int exp_p;
            seg_en = (t % 2) == 1;
            new_frame(t);
            for (int k = 0; k < t; k++)
                send(k, plane_of(k), (k == 0) ? signs_of() : ~signs_of(), 1'b0);
            @(negedge clk);
            chk(layers_rcvd == 4'(t), "R3 count", layers_rcvd, t);
            exp_p = 0;
            for (int k = 1; k < t; k++) if (seg_en && (k % SL) == 0) exp_p++;
            chk(seg_pulses == exp_p, "R10 pulses", seg_pulses, exp_p);
            drain(t, (t == 3) ? 3 : 0, 1'b1);
        end

        // R9: planes refused while idle.
        plane_valid = 1'b1;
        plane_layer = 3'd0;
        plane_bits  = '1;
        repeat (2) @(negedge clk);
        chk(!plane_ready && layers_rcvd == MW, "R9 idle refuse", layers_rcvd, MW);
        plane_valid = 1'b0;

        // R6: plane together with truncate is applied.
        seg_en = 1'b0;
        new_frame(20);
        send(0, plane_of(0), signs_of(), 1'b0);
        send(1, plane_of(1), ~signs_of(), 1'b1);
        chk(layers_rcvd == 2 && rd_valid, "R6", layers_rcvd, 2);
        drain(2, 0, 1'b0);

        // R5: skipped layer is discarded and flagged.
        new_frame(21);
        send(0, plane_of(0), signs_of(), 1'b0);
        send(2, ~plane_of(2), signs_of(), 1'b0);
        chk(order_err && layers_rcvd == 1, "R5 flag", layers_rcvd, 1);
        send(1, plane_of(1), signs_of(), 1'b0);
        chk(order_err && layers_rcvd == 2, "R5 sticky", order_err, 1);
        drain(2, 0, 1'b1);

        // R11: planes past the last layer are out of order.
        seg_en = 1'b1;
        new_frame(22);
        for (int k = 0; k < MW; k++) send(k, plane_of(k), signs_of(), 1'b0);
        chk(!order_err, "R11 clean", order_err, 0);
        send(0, '1, ~signs_of(), 1'b0);
        send(6, '1, ~signs_of(), 1'b0);
        chk(order_err && layers_rcvd == MW, "R11", layers_rcvd, MW);
        drain(MW, 0, 1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule